// File: doc/BRIEF.md
# Halt/Sleep Power-State and Wake Source Controller

This block holds a 16-bit power control word. Software uses it to put the chip into one of two low-power states, and the block decides when to leave them. Halt stops only the processor clock: peripherals, including the USB engines, keep their clock, and the booster stays on. Sleep stops the processor clock and the peripheral clock and turns off the booster.

Either state ends when an event arrives from a source whose wake-enable bit is set. The possible sources are:
- four host/device ports
- the OTG logic
- the high-speed serial port
- the SPI port
- the host port interface
- the general-purpose input

On a wake, the low-power request bits clear, the peripheral clock and the booster return at once, and a resume counter models the firmware restart latency. When that counter expires, the processor clock enable comes back together with a one-cycle wake pulse. The booster's rail status can be read live through a read-only bit. The block generates no clocks itself; it only drives enables for them.

Top module: `pwr_state_ctl`

## Requirements
- R1: After reset, the read word is zero except bit 2, which shows `rail_low`. `cpu_clk_en`, `per_clk_en` and `boost_en` are 1 and `wake_pulse` is 0.
- R2: A write stores the wake enables. The bit positions are:
  - bit 15 = port 3, bit 14 = port 2, bit 13 = port 1, bit 12 = port 0
  - bit 11 = OTG, bit 9 = serial, bit 8 = SPI, bit 7 = host port, bit 5 = GPI
  - Bits 10, 6, 4 and 3 always read 0.
- R3: Bit 2 reads `rail_low` live (1 means the rails are below 3.0 V). Writes to bit 2 have no effect.
- R4: In run, a write with bit 0 set and bit 1 clear enters halt on the next cycle. In halt, `cpu_clk_en`=0, `per_clk_en`=1, `boost_en`=1, and bit 0 reads 1.
- R5: In run, a write with bit 1 set enters sleep on the next cycle. In sleep, all three enables are 0 and bit 1 reads 1. Bit 1 wins over bit 0: bit 0 then reads 0.
- R6: An event whose enable bit is 0 leaves halt or sleep unchanged.
- R7: An enabled event sampled in halt or sleep has these effects one cycle later:
  - bits 1:0 read 0;
  - `per_clk_en`=1 and `boost_en`=1;
  - `cpu_clk_en` stays 0 for `WAKE_DLY` cycles in total, then returns to 1.
- R8: `wake_pulse` is 1 for exactly one cycle: the first cycle in which `cpu_clk_en` is back to 1.
- R9: Events in run or during the resume delay have no effect. Halt or sleep request bits written during the resume delay are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word |
| port_evt | input | 4 | Wake events from host/device ports 0..3 |
| otg_evt | input | 1 | OTG wake event |
| hss_evt | input | 1 | High-speed serial wake event |
| spi_evt | input | 1 | SPI wake event |
| hpi_evt | input | 1 | Host port interface wake event |
| gpi_evt | input | 1 | General-purpose input wake event |
| rail_low | input | 1 | Booster rails below 3.0 V |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock tree enable |
| boost_en | output | 1 | Booster enable |
| wake_pulse | output | 1 | One-cycle pulse when the processor resumes |

## Verification
A wrong state value shows at the ports in the cycle after the edge that loaded it. A stuck halt or sleep shows as a request bit that stays set and clock enables that stay low after an enabled event. A wrong mask decode shows up in either of two ways: a masked source wakes the block, or an enabled source leaves it asleep. Each source is therefore fired alone. A miscounted resume delay moves the rise of `cpu_clk_en` and `wake_pulse` off the exact cycle `WAKE_DLY` edges after the event, so every resume cycle is sampled.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_PORTS = 4;

    localparam int BIT_HALT  = 0;
    localparam int BIT_SLEEP = 1;
    localparam int BIT_RAIL  = 2;
    localparam int BIT_GPI   = 5;
    localparam int BIT_HPI   = 7;
    localparam int BIT_SPI   = 8;
    localparam int BIT_HSS   = 9;
    localparam int BIT_OTG   = 11;
    localparam int BIT_PORT0 = 12;

    // writable wake-enable positions
    localparam logic [REG_W-1:0] WAKE_EN_MASK = 16'hFBA0;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_HALT   = 2'd1,
        PS_SLEEP  = 2'd2,
        PS_RESUME = 2'd3
    } pstate_e;
endpackage

// File: rtl/psc_wake_mask.sv
module psc_wake_mask
    import pwr_state_pkg::*;
(
    input  logic [NUM_PORTS-1:0] port_evt,
    input  logic                 otg_evt,
    input  logic                 hss_evt,
    input  logic                 spi_evt,
    input  logic                 hpi_evt,
    input  logic                 gpi_evt,
    input  logic [REG_W-1:0]     en_vec,
    output logic                 wake_hit
);
    logic [REG_W-1:0] ev_vec;

    always_comb begin
        ev_vec = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            ev_vec[BIT_PORT0 + i] = port_evt[i];
        end
        ev_vec[BIT_OTG] = otg_evt;
        ev_vec[BIT_HSS] = hss_evt;
        ev_vec[BIT_SPI] = spi_evt;
        ev_vec[BIT_HPI] = hpi_evt;
        ev_vec[BIT_GPI] = gpi_evt;
    end

    assign wake_hit = |(ev_vec & en_vec & WAKE_EN_MASK);
endmodule

// File: rtl/psc_resume_timer.sv
module psc_resume_timer #(
    parameter int WAKE_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
    localparam logic [CW-1:0] LOAD = CW'(WAKE_DLY - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done = tmr_q.run && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LOAD;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
    import pwr_state_pkg::*;
#(
    parameter int WAKE_DLY = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_PORTS-1:0] port_evt,
    input  logic                 otg_evt,
    input  logic                 hss_evt,
    input  logic                 spi_evt,
    input  logic                 hpi_evt,
    input  logic                 gpi_evt,
    input  logic                 rail_low,
    output logic                 cpu_clk_en,
    output logic                 per_clk_en,
    output logic                 boost_en,
    output logic                 wake_pulse
);
    typedef struct packed {
        pstate_e          state;
        logic [REG_W-1:0] en;
        logic             pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wake_hit;
    logic tmr_start;
    logic tmr_done;

    psc_wake_mask i_mask (
        .port_evt (port_evt),
        .otg_evt  (otg_evt),
        .hss_evt  (hss_evt),
        .spi_evt  (spi_evt),
        .hpi_evt  (hpi_evt),
        .gpi_evt  (gpi_evt),
        .en_vec   (ctl_q.en),
        .wake_hit (wake_hit)
    );

    psc_resume_timer #(.WAKE_DLY(WAKE_DLY)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.pulse = 1'b0;
        tmr_start   = 1'b0;
        if (wr_en) begin
            ctl_d.en = wr_data & WAKE_EN_MASK;
        end
        case (ctl_q.state)
            PS_RUN: begin
                if (wr_en && wr_data[BIT_SLEEP]) begin
                    ctl_d.state = PS_SLEEP;
                end else if (wr_en && wr_data[BIT_HALT]) begin
                    ctl_d.state = PS_HALT;
                end
            end
            PS_HALT, PS_SLEEP: begin
                if (wake_hit) begin
                    ctl_d.state = PS_RESUME;
                    tmr_start   = 1'b1;
                end
            end
            PS_RESUME: begin
                if (tmr_done) begin
                    ctl_d.state = PS_RUN;
                    ctl_d.pulse = 1'b1;
                end
            end
            default: ctl_d.state = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: PS_RUN, en: '0, pulse: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_data            = ctl_q.en;
        rd_data[BIT_RAIL]  = rail_low;
        rd_data[BIT_SLEEP] = (ctl_q.state == PS_SLEEP);
        rd_data[BIT_HALT]  = (ctl_q.state == PS_HALT);
    end

    assign cpu_clk_en = (ctl_q.state == PS_RUN);
    assign per_clk_en = (ctl_q.state != PS_SLEEP);
    assign boost_en   = (ctl_q.state != PS_SLEEP);
    assign wake_pulse = ctl_q.pulse;
endmodule

// File: rtl/psc_checker.sv
module psc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] rsvd_bits,
    input logic [1:0] req_bits,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       boost_en,
    input logic       wake_pulse
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_bits == 4'b0000); // R2

    AST_HALT_PER_ON: assert property (@(posedge clk) disable iff (!rst_n)
        req_bits[0] |-> (!cpu_clk_en && per_clk_en && boost_en)); // R4

    AST_SLEEP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        req_bits[1] |-> (!cpu_clk_en && !per_clk_en && !boost_en)); // R5

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_bits)); // R5

    AST_WAKE_CPU_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_clk_en) |-> !cpu_clk_en); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R8

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> wake_pulse); // R8

    AST_PULSE_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (cpu_clk_en && $past(!cpu_clk_en))); // R8
endmodule

bind pwr_state_ctl psc_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsvd_bits  ({rd_data[10], rd_data[6], rd_data[4], rd_data[3]}),
    .req_bits   (rd_data[1:0]),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .boost_en   (boost_en),
    .wake_pulse (wake_pulse)
);

// File: tb/test_pwr_state_ctl.sv
`timescale 1ns/1ps
module test_pwr_state_ctl;
    localparam int WAKE_DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [8:0]  src = '0;   // 0..3 ports, 4 otg, 5 hss, 6 spi, 7 hpi, 8 gpi
    logic        rail_low = 1'b0;
    logic        cpu_clk_en, per_clk_en, boost_en, wake_pulse;

    int total = 0;
    int fails = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    pwr_state_ctl #(.WAKE_DLY(WAKE_DLY)) i_pwr_state_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .port_evt(src[3:0]), .otg_evt(src[4]),
        .hss_evt(src[5]), .spi_evt(src[6]), .hpi_evt(src[7]),
        .gpi_evt(src[8]), .rail_low(rail_low), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .boost_en(boost_en), .wake_pulse(wake_pulse)
    );

    function automatic int en_bit(int i);
        case (i)
            0: return 12; 1: return 13; 2: return 14; 3: return 15;
            4: return 11; 5: return 9;  6: return 8;  7: return 7;
            default: return 5;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic fire(input logic [8:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        src = '0;
    endtask

    task automatic check_resume(input string tag);
        chk({tag, " R7 req bits clear"}, rd_data[1:0], 2'b00);
        chk({tag, " R7 per on"}, {per_clk_en, boost_en}, 2'b11);
        chk({tag, " R7 cpu off"}, cpu_clk_en, 1'b0);
        for (int k = 1; k < WAKE_DLY; k++) begin
            @(negedge clk);
            chk({tag, " R7 cpu held off"}, cpu_clk_en, 1'b0);
            chk({tag, " R8 no early pulse"}, wake_pulse, 1'b0);
        end
        @(negedge clk);
        chk({tag, " R7 cpu back"}, cpu_clk_en, 1'b1);
        chk({tag, " R8 pulse"}, wake_pulse, 1'b1);
        @(negedge clk);
        chk({tag, " R8 pulse once"}, wake_pulse, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 rd", rd_data, 16'h0000);
        chk("R1 enables", {cpu_clk_en, per_clk_en, boost_en, wake_pulse}, 4'b1110);
    endtask

    task automatic t_fields();
        write(16'hFFF8);
        chk("R2 en fields", rd_data, 16'hFBA0);
        write(16'h045C);
        chk("R2 rsvd and R3 write", rd_data, 16'h0000);
        rail_low = 1'b1;
        @(negedge clk);
        chk("R3 rail bit", rd_data, 16'h0004);
        rail_low = 1'b0;
        @(negedge clk);
        chk("R3 rail clear", rd_data, 16'h0000);
    endtask

    task automatic t_halt();
        write(16'h8001);
        chk("R4 halt rd", rd_data, 16'h8001);
        chk("R4 halt en", {cpu_clk_en, per_clk_en, boost_en}, 3'b011);
        fire(9'h008);
        check_resume("halt");
        chk("R7 halt rd after", rd_data, 16'h8000);
    endtask

    task automatic t_sleep_each();
        for (int i = 0; i < 9; i++) begin
            logic [15:0] en;
            en = 16'h0;
            en[en_bit(i)] = 1'b1;
            write(en | 16'h0003);
            chk($sformatf("R5 sleep rd src%0d", i), rd_data, {16'(en | 16'h0002)});
            chk("R5 sleep en", {cpu_clk_en, per_clk_en, boost_en}, 3'b000);
            fire(9'h1FF & ~(9'h1 << i));
            chk($sformatf("R6 masked src%0d", i), rd_data[1:0], 2'b10);
            chk("R6 still off", per_clk_en, 1'b0);
            fire(9'h1 << i);
            check_resume($sformatf("sleep src%0d", i));
        end
    endtask

    task automatic t_ignored();
        write(16'hFBA0);
        fire(9'h1FF);
        chk("R9 run ignores events", {cpu_clk_en, wake_pulse, rd_data[1:0]}, 4'b1000);
        write(16'h0021);
        fire(9'h100);
        // resume in progress: write halt+sleep, must be ignored
        write(16'h0003);
        for (int k = 0; k < WAKE_DLY + 2; k++) @(negedge clk);
        chk("R9 resume ignores req", rd_data, 16'h0000);
        chk("R9 back to run", {cpu_clk_en, per_clk_en, boost_en}, 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_halt();
        t_sleep_each();
        t_ignored();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end
endmodule